// File: doc/BRIEF.md
# Idle-Qualified Hint Clock Gate Controller

This block decides, for each of a parameterised set of transactional units (accelerators and similar engines that work on a job and then go quiet), whether that unit's clock should run. Software sets or clears one hint bit per unit to say that a unit's clock may be stopped. A cleared hint only asks for the clock to stop. The clock stays on as long as the unit reports that it is busy, and it stops on the cycle after the unit reports that it is idle.

Two chip-level controls take precedence over the hints. A scan-mode input forces every unit clock on. When scan mode is off, a power-controller clock enable that is low turns every unit clock off. The status vector comes from the same registered enables that drive the clock gates. A status bit therefore reads one exactly while the matching clock is running, and it never reports a gate as closed before the gate has closed.

Top module: `hint_clk_gate`

## Requirements
- R1: While reset is held and on the first cycle after it is released, every hint bit is one, every bit of `unit_clk_en_o` is one and every bit of `status_o` is one.
- R2: `status_o[i]` equals `unit_clk_en_o[i]` for every unit, in every cycle.
- R3: With `scan_en_i` low and `pwr_clk_en_i` high, `unit_clk_en_o[i]` one clock edge after a given edge equals the stored hint bit i ORed with the inverse of `idle_i[i]`, both taken at that given edge.
- R4: When every `idle_i` bit is one (scan off, power enable high), `status_o` equals the stored hint vector exactly.
- R5: A unit whose hint is cleared keeps its clock enabled while its `idle_i` bit is zero. The enable drops on the first clock edge that samples `idle_i` high.
- R6: A write strobe `hint_we_i` high at a clock edge replaces the whole hint vector with `hint_wdata_i`. Bit i of the hint vector belongs to unit i. With the strobe low, the stored hints do not change.
- R7: If a unit's hint is set again while its clock is off, its enable returns to one on the edge after the hint register takes the new value, even when its idle input is one.
- R8: When `scan_en_i` is high at an edge, every `unit_clk_en_o` bit is one after that edge, whatever the hints, idle inputs and power enable are.
- R9: When `scan_en_i` is low and `pwr_clk_en_i` is low at an edge, every `unit_clk_en_o` bit and every `status_o` bit is zero after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hint_we_i | input | 1 | Write strobe for the hint vector |
| hint_wdata_i | input | NUM_UNITS | New hint vector; 1 keeps the unit's clock on, 0 asks for it to stop |
| idle_i | input | NUM_UNITS | Per-unit idle report, 1 = idle |
| pwr_clk_en_i | input | 1 | Global clock enable from the power controller |
| scan_en_i | input | 1 | Scan-mode override, forces all unit clocks on |
| unit_clk_en_o | output | NUM_UNITS | Registered per-unit clock-gate enables |
| status_o | output | NUM_UNITS | Per-unit status, 1 = clock running |

## Verification
The bench clears hints on units that are still busy and checks that their clocks keep running. A design that only echoed the hint would stop a busy unit's clock early. The bench then raises idle and checks that the clock stops on exactly the next edge; a missing register, or one too many, moves that edge. It sets a hint again on a unit that is idle and gated, and checks that the clock comes back even though idle stays high; a design that waited for a busy indication would leave the unit stuck off. It also checks that scan mode overrides the power enable and that a low power enable clears the status vector, so a design with the wrong priority between scan mode and the power enable would fail.

// File: rtl/hcg_pkg.sv
package hcg_pkg;

  typedef enum logic [1:0] {
    GATE_FOLLOW = 2'd0,
    GATE_FORCE_ON = 2'd1,
    GATE_FORCE_OFF = 2'd2
  } gate_mode_e;

  function automatic gate_mode_e pick_mode(input logic scan, input logic pwr_en);
    gate_mode_e m;
    if (scan) m = GATE_FORCE_ON;
    else if (!pwr_en) m = GATE_FORCE_OFF;
    else m = GATE_FOLLOW;
    return m;
  endfunction

endpackage

// File: rtl/hcg_mode_dec.sv
module hcg_mode_dec
  import hcg_pkg::*;
(
  input  logic       scan_en_i,
  input  logic       pwr_clk_en_i,
  output gate_mode_e mode_o
);
  always_comb begin
    mode_o = pick_mode(scan_en_i, pwr_clk_en_i);
  end
endmodule

// File: rtl/hcg_hint_reg.sv
module hcg_hint_reg #(
  parameter int unsigned NUM_UNITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [NUM_UNITS-1:0] wdata_i,
  output logic [NUM_UNITS-1:0] hint_o
);
  localparam logic [NUM_UNITS-1:0] HintRst = {NUM_UNITS{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hint_o <= HintRst;
    else if (we_i) hint_o <= wdata_i;
  end
endmodule

// File: rtl/hcg_unit_gate.sv
module hcg_unit_gate
  import hcg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  gate_mode_e mode_i,
  input  logic       hint_i,
  input  logic       idle_i,
  output logic       en_o
);
  logic en_d;

  always_comb begin
    unique case (mode_i)
      GATE_FORCE_ON:  en_d = 1'b1;
      GATE_FORCE_OFF: en_d = 1'b0;
      default:        en_d = hint_i | ~idle_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b1;
    else en_o <= en_d;
  end
endmodule

// File: rtl/hint_clk_gate.sv
module hint_clk_gate
  import hcg_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hint_we_i,
  input  logic [NUM_UNITS-1:0] hint_wdata_i,
  input  logic [NUM_UNITS-1:0] idle_i,
  input  logic                 pwr_clk_en_i,
  input  logic                 scan_en_i,
  output logic [NUM_UNITS-1:0] unit_clk_en_o,
  output logic [NUM_UNITS-1:0] status_o
);
  gate_mode_e           mode;
  logic [NUM_UNITS-1:0] hint_q;
  logic [NUM_UNITS-1:0] en_q;

  hcg_mode_dec u_mode (
    .scan_en_i    (scan_en_i),
    .pwr_clk_en_i (pwr_clk_en_i),
    .mode_o       (mode)
  );

  hcg_hint_reg #(.NUM_UNITS(NUM_UNITS)) u_hint (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (hint_we_i),
    .wdata_i (hint_wdata_i),
    .hint_o  (hint_q)
  );

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    hcg_unit_gate u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .mode_i (mode),
      .hint_i (hint_q[g]),
      .idle_i (idle_i[g]),
      .en_o   (en_q[g])
    );
  end

  // Status is sourced from the registered enable that drives the gate.
  assign unit_clk_en_o = en_q;
  assign status_o      = en_q;
endmodule

// File: rtl/hint_clk_gate_chk.sv
module hint_clk_gate_chk #(
  parameter int unsigned NUM_UNITS = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 scan_en_i,
  input logic                 pwr_clk_en_i,
  input logic [NUM_UNITS-1:0] idle_i,
  input logic [NUM_UNITS-1:0] hint_q,
  input logic [NUM_UNITS-1:0] unit_clk_en_o,
  input logic [NUM_UNITS-1:0] status_o
);
  localparam logic [NUM_UNITS-1:0] AllOn = {NUM_UNITS{1'b1}};

  // R1
  reset_all_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (unit_clk_en_o == AllOn));

  // R2
  status_matches_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == unit_clk_en_o);

  // R3
  follow_hint_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_clk_en_i && !scan_en_i) |=> (unit_clk_en_o == $past(hint_q | ~idle_i)));

  // R5
  busy_stays_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_clk_en_i && !scan_en_i) |=> ((unit_clk_en_o | $past(idle_i)) == AllOn));

  // R8
  scan_forces_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_i |=> (unit_clk_en_o == AllOn));

  // R9
  pwr_off_gates_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_en_i && !pwr_clk_en_i) |=> (status_o == '0));
endmodule

bind hint_clk_gate hint_clk_gate_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .scan_en_i     (scan_en_i),
  .pwr_clk_en_i  (pwr_clk_en_i),
  .idle_i        (idle_i),
  .hint_q        (hint_q),
  .unit_clk_en_o (unit_clk_en_o),
  .status_o      (status_o)
);

// File: tb/sim_hint_clk_gate.sv
`timescale 1ns/1ps
module sim_hint_clk_gate;
  localparam int N = 4;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         we = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] idle = '1;
  logic         pwr = 1'b1;
  logic         scan = 1'b0;
  logic [N-1:0] en;
  logic [N-1:0] st;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hint_clk_gate #(.NUM_UNITS(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hint_we_i(we), .hint_wdata_i(wdata),
    .idle_i(idle), .pwr_clk_en_i(pwr), .scan_en_i(scan),
    .unit_clk_en_o(en), .status_o(st)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Both outputs checked together; R2 says they must agree.
  task automatic check_both(input string req, input logic [N-1:0] exp);
    check(req, en, exp);
    check({req, "/R2"}, st, exp);
  endtask

  task automatic write_hint(input logic [N-1:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_both("R1 during reset", '1);
    rst_n = 1'b1;
    @(negedge clk);
    check_both("R1 after release", '1);
  endtask

  task automatic t_follow();
    logic [N-1:0] hints [3] = '{4'b0000, 4'b0101, 4'b1010};
    logic [N-1:0] idles [3] = '{4'b0110, 4'b1100, 4'b0011};
    pwr = 1'b1; scan = 1'b0;
    for (int k = 0; k < 3; k++) begin
      idle = idles[k];
      write_hint(hints[k]);
      settle();
      check_both("R3 hint|~idle", hints[k] | ~idles[k]);
    end
  endtask

  task automatic t_all_idle();
    idle = '1;
    write_hint(4'b1001);
    settle();
    check_both("R4 all idle equals hints", 4'b1001);
    write_hint(4'b0110);
    settle();
    check_both("R6 full vector replaced", 4'b0110);
    // Strobe low: data on the bus must not be taken.
    @(negedge clk); wdata = 4'b1001;
    settle();
    check_both("R6 no strobe no change", 4'b0110);
  endtask

  task automatic t_clear_busy();
    idle = '1;
    write_hint('1);
    settle();
    idle = 4'b1011;              // unit 2 busy
    write_hint(4'b0000);
    settle();
    check_both("R5 busy unit keeps clock", 4'b0100);
    idle = 4'b1111;              // unit 2 goes idle before next edge
    @(negedge clk);
    check_both("R5 drops one edge after idle", 4'b0000);
  endtask

  task automatic t_rehint();
    idle = '1;
    write_hint(4'b0000);
    settle();
    check_both("R7 all gated", 4'b0000);
    @(negedge clk); we = 1'b1; wdata = 4'b0010;
    @(negedge clk); we = 1'b0;   // hint register updated at the edge just passed
    check_both("R7 not yet on", 4'b0000);
    @(negedge clk);
    check_both("R7 back on while idle", 4'b0010);
  endtask

  task automatic t_scan();
    idle = '1; pwr = 1'b0;
    write_hint(4'b0000);
    settle();
    check_both("R9 pwr low gates all", 4'b0000);
    @(negedge clk); scan = 1'b1;
    @(negedge clk);
    check_both("R8 scan overrides pwr", '1);
    @(negedge clk); scan = 1'b0;
    @(negedge clk);
    check_both("R9 pwr low after scan", 4'b0000);
    idle = 4'b0000;
    settle();
    check_both("R9 busy units still off", 4'b0000);
    pwr = 1'b1;
    @(negedge clk);
    check_both("R3 busy units resume", '1);
    idle = '1;
    @(negedge clk);
    check_both("R4 idle with empty hints", 4'b0000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_follow();
        t_all_idle();
        t_clear_busy();
        t_rehint();
        t_scan();
        done = 1'b1;
      end
      begin
        repeat (WATCHDOG_CYCLES) @(negedge clk);
        if (!done) begin
          n_checks++;
          n_fail++;
          $display("FAIL watchdog: actual=timeout expected=completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule